// File: doc/BRIEF.md
# Test Pattern Generator and Checker

This block is a bring-up aid for a serial data link. Its transmit side emits one parallel word per clock. That word is either user data passed through, a pseudo-random binary sequence (PRBS) from a linear feedback shift register (LFSR), or an incrementing ramp. Its receive side takes parallel words qualified by a valid strobe. It synchronises itself to the same pattern without any seed exchange. It then holds a sticky error flag once any received word differs from the word it predicts.

A parameter picks the polynomial from a fixed set of five. The LFSR length equals the polynomial order, so the sequence repeats every 2^n − 1 bits. The LFSR advances by a full word each clock, with every bit of that word worked out in the same cycle. The transmit and receive sides share one mode input. The checker takes its expected state from the first usable word it receives and then runs free. A mismatch does not cause it to resynchronise.

Top module: `pattern_gen_check`

## Requirements
- R1: The `mode` input selects the transmit word, which is registered one cycle after the input. 4'b0000 passes `user_data` through. 4'b0001 sends PRBS. 4'b0010 sends a ramp. Every other value behaves as 4'b0000.
- R2: `TAP` selects the polynomial: 6 gives x^7+x^6+1, 5 gives x^9+x^5+1, 14 gives x^15+x^14+1, 18 gives x^23+x^18+1 and 28 gives x^31+x^28+1. Each serial bit is s[n-1] xor s[TAP-1] and is shifted into s[0]. Each word carries W successive bits, the earliest in bit W-1. The bit sequence repeats every 2^n − 1 bits, so with the defaults (W=32, n=7) word 127 equals word 0.
- R3: Reset loads the generator LFSR with all ones, and the generator state is never all zero. The generator advances only in PRBS mode.
- R4: In ramp mode the transmit word starts at 0 after reset and rises by one each clock, wrapping at 2^W.
- R5: Words with `rx_valid` low change neither `locked` nor `err`.
- R6: In PRBS mode, the first valid word while unlocked loads the expected state from its low n bits and sets `locked` the next cycle. That word is not compared.
- R7: While locked in PRBS mode, every valid word is compared with the predicted word, and any difference sets `err`. The prediction advances one word per valid word whether or not that word matched.
- R8: A valid word whose low n bits are all zero does not lock the PRBS checker.
- R9: In ramp mode, the first valid word while unlocked sets `locked`. After that, each valid word must equal the previous valid word plus one, wrapping at 2^W, or `err` is set.
- R10: `err` stays set until `err_clr` is high at a clock edge. `err_clr` takes priority over a mismatch in the same cycle.
- R11: A change of `mode` clears `locked` on that clock edge, and no compare happens in that cycle.
- R12: Synchronous reset drives `tx_data`, `err` and `locked` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Operating mode: user, PRBS or ramp |
| user_data | input | W | Word passed through in user mode |
| tx_data | output | W | Transmitted word |
| rx_valid | input | 1 | Qualifies rx_data |
| rx_data | input | W | Received word |
| err_clr | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky mismatch flag |
| locked | output | 1 | Checker synchronised to the pattern |

## Verification
The assertions assume that `mode` is held steady over the checker's window, apart from deliberate changes. They also assume that the word width is at least the polynomial order, so that one word fully defines the LFSR state. The stimulus holds the mode for whole test phases and changes it only where the resynchronisation rule is being exercised. It runs with the default width of 32 and order of 7. Received PRBS words come from the bench's own serial model of the polynomial. Errors are injected by flipping one bit.

// File: rtl/pattern_gen_check.sv
module pattern_gen_check #(
  parameter int W   = 32,
  parameter int TAP = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   mode,
  input  logic [W-1:0] user_data,
  output logic [W-1:0] tx_data,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  input  logic         err_clr,
  output logic         err,
  output logic         locked
);
  localparam int ORD = (TAP == 5)  ? 9  :
                       (TAP == 6)  ? 7  :
                       (TAP == 14) ? 15 :
                       (TAP == 18) ? 23 : 31;
  localparam logic [3:0] M_PRBS = 4'b0001;
  localparam logic [3:0] M_RAMP = 4'b0010;

  initial begin
    assert (TAP == 5 || TAP == 6 || TAP == 14 || TAP == 18 || TAP == 28)
      else $error("TAP must be one of 5, 6, 14, 18, 28");
    assert (W >= ORD) else $error("W must be at least the polynomial order");
  end

  function automatic logic [ORD-1:0] lfsr_adv(input logic [ORD-1:0] s);
    logic [ORD-1:0] t;
    t = s;
    for (int i = 0; i < W; i++) t = {t[ORD-2:0], t[ORD-1] ^ t[TAP-1]};
    return t;
  endfunction

  function automatic logic [W-1:0] lfsr_word(input logic [ORD-1:0] s);
    logic [ORD-1:0] t;
    logic [W-1:0]   w;
    logic           b;
    t = s;
    w = '0;
    for (int i = 0; i < W; i++) begin
      b = t[ORD-1] ^ t[TAP-1];
      w[W-1-i] = b;
      t = {t[ORD-2:0], b};
    end
    return w;
  endfunction

  logic [ORD-1:0] gen_st, chk_st;
  logic [W-1:0]   ramp_cnt, last_rx;
  logic [3:0]     mode_q;

  wire is_prbs  = (mode == M_PRBS);
  wire is_ramp  = (mode == M_RAMP);
  wire mode_chg = (mode != mode_q);
  wire [W-1:0] exp_word = lfsr_word(chk_st);
  wire miss = rx_valid && locked && !mode_chg &&
              ((is_prbs && rx_data != exp_word) ||
               (is_ramp && rx_data != last_rx + 1'b1));

  // transmit side
  always_ff @(posedge clk) begin
    if (rst) begin
      gen_st   <= '1;
      ramp_cnt <= '0;
      tx_data  <= '0;
    end else if (is_prbs) begin
      gen_st  <= lfsr_adv(gen_st);
      tx_data <= lfsr_word(gen_st);
    end else if (is_ramp) begin
      ramp_cnt <= ramp_cnt + 1'b1;
      tx_data  <= ramp_cnt;
    end else begin
      tx_data <= user_data;
    end
  end

  // receive side
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_st  <= '1;
      last_rx <= '0;
      locked  <= 1'b0;
      mode_q  <= '0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        locked <= 1'b0;
      end else if (rx_valid && is_prbs) begin
        if (locked) begin
          chk_st <= lfsr_adv(chk_st);
        end else if (rx_data[ORD-1:0] != '0) begin
          chk_st <= rx_data[ORD-1:0];
          locked <= 1'b1;
        end
      end else if (rx_valid && is_ramp) begin
        last_rx <= rx_data;
        locked  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err <= 1'b0;
    else if (err_clr) err <= 1'b0;
    else if (miss)    err <= 1'b1;
  end

  assert_pass_through_R1: assert property (@(posedge clk) disable iff (rst)
    (mode != M_PRBS && mode != M_RAMP) |=> tx_data == $past(user_data));

  assert_gen_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    gen_st != '0);

  assert_ramp_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == M_RAMP && is_ramp) |=> tx_data == $past(tx_data) + 1'b1);

  assert_idle_no_err_R5: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !$rose(err));

  assert_zero_seed_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && is_prbs && !locked && rx_data[ORD-1:0] == '0) |=> !locked);

  assert_err_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (err && !err_clr) |=> err);

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> !err);

  assert_mode_unlock_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && mode != $past(mode)) |=> !locked);
endmodule

// File: tb/pattern_gen_check_test.sv
module pattern_gen_check_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  mode = 4'b0001;
  logic [31:0] user_data = '0;
  logic [31:0] tx_data;
  logic        rx_valid = 1'b0;
  logic [31:0] rx_data = '0;
  logic        err_clr = 1'b0;
  logic        err, locked;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pattern_gen_check #(.W(32), .TAP(6)) uut (
    .clk(clk), .rst(rst), .mode(mode), .user_data(user_data), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .err_clr(err_clr), .err(err), .locked(locked)
  );

  // serial model of x^7+x^6+1: returns {next state, word}, first bit in word MSB
  function automatic logic [38:0] mstep(input logic [6:0] s);
    logic [31:0] w;
    logic        b;
    w = '0;
    for (int i = 0; i < 32; i++) begin
      b = s[6] ^ s[5];
      w = {w[30:0], b};
      s = {s[5:0], b};
    end
    return {s, w};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clocked step: drive at negedge, sample 2 ns after the rising edge
  task automatic step(input logic v, input logic [31:0] d, input logic c);
    @(negedge clk);
    rx_valid = v;
    rx_data  = d;
    err_clr  = c;
    @(posedge clk);
    #2;
  endtask

  // {valid, flip, clr, exp_locked, exp_err}
  localparam logic [4:0] SEQ [12] = '{
    5'b00000,  // R5 invalid while unlocked
    5'b10010,  // R6 lock on first valid word
    5'b10010,  // R7 match
    5'b00010,  // R5 invalid while locked
    5'b10010,
    5'b11011,  // R7 flipped bit
    5'b10011,  // R10 sticky
    5'b00110,  // R10 clear
    5'b10010,  // R7 prediction kept running
    5'b11110,  // R10 clear beats mismatch
    5'b10010,
    5'b10010
  };

  initial begin
    logic [6:0]  ms;
    logic [31:0] w, first;
    bit          ok;

    repeat (3) @(posedge clk);
    #2;
    check("R12 tx_data reset", tx_data, 32'h0);
    check("R12 err reset", {31'h0, err}, 32'h0);
    check("R12 locked reset", {31'h0, locked}, 32'h0);

    // generator: PRBS from all-ones seed, then period
    @(negedge clk);
    rst = 1'b0;
    ms = 7'h7F;
    ok = 1'b1;
    first = '0;
    for (int k = 0; k < 128; k++) begin
      @(posedge clk);
      #2;
      if (k == 0) begin
        {ms, w} = mstep(ms);
        first = w;
        check("R3 first word from all-ones seed", tx_data, w);
      end else if (k < 127) begin
        {ms, w} = mstep(ms);
        if (tx_data !== w) ok = 1'b0;
      end else begin
        check("R2 period 127 words", tx_data, first);
      end
    end
    check("R2 PRBS words 1..126", {31'h0, ok}, 32'h1);

    // checker table in PRBS mode
    ms = 7'h13;
    for (int i = 0; i < 12; i++) begin
      logic [4:0] e;
      logic [31:0] d;
      e = SEQ[i];
      d = 32'hDEADBEEF;
      if (e[4]) begin
        {ms, w} = mstep(ms);
        d = e[3] ? (w ^ 32'h8000_0000) : w;
      end
      step(e[4], d, e[2]);
      check($sformatf("R5/R6/R7/R10 step %0d locked", i), {31'h0, locked}, {31'h0, e[1]});
      check($sformatf("R5/R6/R7/R10 step %0d err", i), {31'h0, err}, {31'h0, e[0]});
    end

    // R11 mode change drops lock
    @(negedge clk);
    mode = 4'b0010;
    step(1'b0, 32'h0, 1'b0);
    check("R11 unlock on mode change", {31'h0, locked}, 32'h0);
    @(negedge clk);
    mode = 4'b0001;
    step(1'b0, 32'h0, 1'b0);
    // R8 zero seed does not lock
    step(1'b1, 32'hFFFF_FF80, 1'b0);
    check("R8 zero low bits no lock", {31'h0, locked}, 32'h0);
    {ms, w} = mstep(ms);
    step(1'b1, w, 1'b0);
    check("R6 relock", {31'h0, locked}, 32'h1);
    {ms, w} = mstep(ms);
    step(1'b1, w, 1'b0);
    check("R7 match after relock", {31'h0, err}, 32'h0);

    // R9 ramp checker
    @(negedge clk);
    mode = 4'b0010;
    step(1'b0, 32'h0, 1'b0);
    step(1'b1, 32'd100, 1'b0);
    check("R9 ramp lock", {31'h0, locked}, 32'h1);
    step(1'b1, 32'd101, 1'b0);
    check("R9 ramp +1 ok", {31'h0, err}, 32'h0);
    step(1'b1, 32'd103, 1'b0);
    check("R9 ramp skip flagged", {31'h0, err}, 32'h1);
    step(1'b1, 32'hFFFF_FFFF, 1'b1);
    check("R10 clear in ramp", {31'h0, err}, 32'h0);
    step(1'b1, 32'h0, 1'b0);
    check("R9 ramp wrap", {31'h0, err}, 32'h0);

    // R4 ramp generator after reset
    @(negedge clk);
    rst = 1'b1;
    rx_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      #2;
      check("R4 ramp value", tx_data, 32'(k));
    end

    // R1 pass-through modes
    @(negedge clk);
    mode = 4'b0000;
    user_data = 32'hA5A5_5A5A;
    @(posedge clk);
    #2;
    check("R1 user mode", tx_data, 32'hA5A5_5A5A);
    @(negedge clk);
    mode = 4'b1111;
    user_data = 32'h1234_5678;
    @(posedge clk);
    #2;
    check("R1 unused mode acts as user", tx_data, 32'h1234_5678);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule